// File: doc/BRIEF.md
# Fast-Write Block Throttle Receiver

This block sits on the receiving end of a host-to-device fast write burst of unbounded length. The data arrives in blocks of a fixed number of common-clock beats, four by default. The receiver paces the burst one whole block at a time. It does not handshake freely on every beat. Each beat that both sides mark ready is passed to a local buffer through a registered write strobe and data pair.

The receiver must always take the first block of a burst. Every later block opens with a throttle cycle. In that cycle target-ready is raised only if the local buffer reports room for at least one full block. Otherwise target-ready stays low, and the decision is made again on every clock until space appears. Inside a block that has been opened, target-ready stays high. The initiator may hold initiator-ready low for a cycle before the first data, and such idle beats never move the block boundary. A handshake made while frame is deasserted is the last beat of the burst. It returns the receiver to its starting state.

Top module: `fw_throttle_rx`

## Requirements
- R1: While `rst` is high, `trdy_o` is low whatever the other inputs do. In the first cycle after reset is released, `wr_en_o` is low.
- R2: With no burst in progress and `frame_i` low, `trdy_o` is low and no write is issued.
- R3: For all four beats of the first block of a burst, `trdy_o` is high, even when `free_i` is 0.
- R4: In the opening beat of every later block, `trdy_o` is high only if `free_i` >= 128. 128 is the block size in bytes: a 32-byte data bus times 4 beats.
- R5: On the second, third and fourth beats of any opened block, `trdy_o` is high whatever the value of `free_i`.
- R6: A stalled opening beat is decided again on every clock. `trdy_o` rises in the same cycle in which `free_i` first reaches 128.
- R7: In the cycle after each clock where `irdy_i` and `trdy_o` are both high, `wr_en_o` is high and `wr_data_o` equals that cycle's `data_i`. In every other cycle `wr_en_o` is low.
- R8: A beat with `trdy_o` high but `irdy_i` low, such as the optional initial wait state, does not advance the beat count. The next throttle cycle still comes after exactly four completed beats.
- R9: A completed beat with `frame_i` low ends the burst. `trdy_o` then falls unless `frame_i` is high again, and the next burst's first block is accepted without any condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | Burst in progress; deasserted together with the final beat |
| irdy_i | input | 1 | Initiator has valid data on `data_i` |
| data_i | input | DATA_W | Write data bus |
| free_i | input | FREE_W | Free bytes in the local buffer |
| trdy_o | output | 1 | Receiver ready for the current beat |
| wr_en_o | output | 1 | Buffer write strobe, one cycle after the handshake |
| wr_data_o | output | DATA_W | Buffer write data |

## Verification
The bench aims at the exact throttle threshold of 127 against 128 bytes. A design that used the wrong comparison would either grant a block it cannot hold or stall a block that fits. It runs the first block with no free space, to catch a design that throttles the block it must always take. It also places an initial wait state before a later throttle point, which catches a beat counter that advances without a handshake and opens the next block one beat early. Finally, it starts a new burst straight after a final beat with no free space, which exposes a counter that does not return to the first-block state and would stall the new burst at once.

// File: rtl/fw_pkg.sv
package fw_pkg;

    // Burst tracking state shared between the counter and the gate.
    typedef struct packed {
        logic in_burst;   // at least one beat of a burst has completed
        logic first_blk;  // current block is the first of the burst
        logic at_open;    // current beat is the opening beat of a block
    } trk_t;

    function automatic int unsigned block_bytes(input int unsigned data_w,
                                                input int unsigned beats);
        return (data_w / 8) * beats;
    endfunction

    function automatic logic has_room(input logic [31:0] free_bytes,
                                      input logic [31:0] need_bytes);
        return free_bytes >= need_bytes;
    endfunction

endpackage

// File: rtl/fw_beat_tracker.sv
module fw_beat_tracker
    import fw_pkg::*;
#(
    parameter int unsigned BEATS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_i,
    input  logic xfer_i,
    output trk_t st_o
);
    localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    logic [BW-1:0] beat_q;
    logic          first_q;
    logic          inb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            first_q <= 1'b1;
            inb_q   <= 1'b0;
        end else if (xfer_i) begin
            if (!frame_i) begin
                beat_q  <= '0;
                first_q <= 1'b1;
                inb_q   <= 1'b0;
            end else begin
                inb_q <= 1'b1;
                if (beat_q == LAST) begin
                    beat_q  <= '0;
                    first_q <= 1'b0;
                end else begin
                    beat_q <= beat_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        st_o.in_burst  = inb_q;
        st_o.first_blk = first_q;
        st_o.at_open   = (beat_q == '0);
    end

    // R8: a beat without a handshake leaves the count where it was
    a_r8_hold_without_xfer: assert property (@(posedge clk) disable iff (rst)
        !xfer_i |=> $stable(beat_q));

    // R9: the final beat returns the tracker to its starting state
    a_r9_end_restarts: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && !frame_i) |=> (st_o.first_blk && st_o.at_open && !st_o.in_burst));

endmodule

// File: rtl/fw_throttle_gate.sv
module fw_throttle_gate
    import fw_pkg::*;
#(
    parameter int unsigned FREE_W = 12,
    parameter int unsigned NEED   = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_i,
    input  trk_t              st_i,
    input  logic [FREE_W-1:0] free_i,
    output logic              trdy_o
);
    logic room;
    logic live;

    always_comb begin
        room   = has_room(32'(free_i), 32'(NEED));
        live   = frame_i || st_i.in_burst;
        trdy_o = !rst && live && (!st_i.at_open || st_i.first_blk || room);
    end

    // R4: a later block opens only when a whole block fits
    a_r4_open_needs_room: assert property (@(posedge clk) disable iff (rst)
        (trdy_o && st_i.at_open && !st_i.first_blk) |-> (32'(free_i) >= 32'(NEED)));

    // R5: inside an opened block the receiver never stalls
    a_r5_mid_block_ready: assert property (@(posedge clk) disable iff (rst)
        (st_i.in_burst && !st_i.at_open) |-> trdy_o);

    // R3: the first block is taken whatever the buffer holds
    a_r3_first_block_ready: assert property (@(posedge clk) disable iff (rst)
        (frame_i && st_i.first_blk) |-> trdy_o);

endmodule

// File: rtl/fw_write_stage.sv
module fw_write_stage #(
    parameter int unsigned DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= xfer_i;
            if (xfer_i) begin
                wr_data_o <= data_i;
            end
        end
    end

    // R7: written data is the bus value of the handshake cycle
    a_r7_data_matches: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_data_o == $past(data_i)));

endmodule

// File: rtl/fw_throttle_rx.sv
module fw_throttle_rx
    import fw_pkg::*;
#(
    parameter int unsigned DATA_W = 256,
    parameter int unsigned BEATS  = 4,
    parameter int unsigned FREE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_i,
    input  logic              irdy_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [FREE_W-1:0] free_i,
    output logic              trdy_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam int unsigned NEED = block_bytes(DATA_W, BEATS);

    trk_t st;
    logic xfer;

    assign xfer = irdy_i && trdy_o;

    fw_beat_tracker #(.BEATS(BEATS)) trk_i (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_i),
        .xfer_i  (xfer),
        .st_o    (st)
    );

    fw_throttle_gate #(.FREE_W(FREE_W), .NEED(NEED)) gate_i (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_i),
        .st_i    (st),
        .free_i  (free_i),
        .trdy_o  (trdy_o)
    );

    fw_write_stage #(.DATA_W(DATA_W)) wr_i (
        .clk       (clk),
        .rst       (rst),
        .xfer_i    (xfer),
        .data_i    (data_i),
        .wr_en_o   (wr_en_o),
        .wr_data_o (wr_data_o)
    );

    // R1: reset holds target-ready low
    always_comb begin
        if (rst) begin
            a_r1_reset_quiet: assert (!trdy_o);
        end
    end

    // R2: nothing happens between bursts
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!frame_i && !st.in_burst) |-> !trdy_o);

    // R7: a write strobe always follows a handshake
    a_r7_write_follows_xfer: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(irdy_i && trdy_o));

endmodule

// File: tb/fw_throttle_rx_tb_top.sv
`timescale 1ns/100ps
module fw_throttle_rx_tb_top;
    localparam int DW   = 256;
    localparam int FW   = 12;
    localparam int NEED = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame = 1'b0;
    logic          irdy = 1'b0;
    logic [DW-1:0] data = '0;
    logic [FW-1:0] free = '0;
    logic          trdy;
    logic          wr_en;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int            m_beat = 0;
    bit            m_first = 1'b1;
    bit            m_inb = 1'b0;
    bit            exp_wr = 1'b0;
    logic [DW-1:0] exp_wd = '0;

    always #2.5 clk = ~clk;

    fw_throttle_rx #(.DATA_W(DW), .BEATS(4), .FREE_W(FW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .frame_i   (frame),
        .irdy_i    (irdy),
        .data_i    (data),
        .free_i    (free),
        .trdy_o    (trdy),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data)
    );

    function automatic bit exp_trdy(input bit f, input int fr);
        return (f || m_inb) && (m_beat != 0 || m_first || fr >= NEED);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit f, input bit ir, input int fr, input string tag);
        logic [DW-1:0] d;
        bit et;
        bit x;
        @(negedge clk);
        chk(wr_en == exp_wr, "R7", "wr_en", DW'(wr_en), DW'(exp_wr));
        if (exp_wr) chk(wr_data == exp_wd, "R7", "wr_data", wr_data, exp_wd);
        for (int k = 0; k < DW / 32; k++) d[k*32 +: 32] = $urandom;
        frame = f; irdy = ir; free = FW'(fr); data = d;
        #1;
        et = exp_trdy(f, fr);
        chk(trdy == et, tag, "trdy", DW'(trdy), DW'(et));
        x = ir && et;
        if (x) begin
            if (!f) begin
                m_beat = 0; m_first = 1'b1; m_inb = 1'b0;
            end else begin
                m_inb = 1'b1;
                if (m_beat == 3) begin m_beat = 0; m_first = 1'b0; end
                else m_beat++;
            end
        end
        exp_wr = x;
        exp_wd = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; frame = 1'b1; irdy = 1'b1; free = '1;
        for (int i = 0; i < 2; i++) begin
            #1;
            chk(trdy == 1'b0, "R1", "trdy in reset", DW'(trdy), '0);
            @(negedge clk);
        end
        rst = 1'b0; frame = 1'b0; irdy = 1'b0;
        m_beat = 0; m_first = 1'b1; m_inb = 1'b0; exp_wr = 1'b0;
        #1;
        chk(wr_en == 1'b0, "R1", "wr_en after reset", DW'(wr_en), '0);
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // R2: idle with frame low
        step(0, 1, 4095, "R2");
        step(0, 1, 4095, "R2");

        // R3: first block with an empty buffer
        for (int i = 0; i < 4; i++) step(1, 1, 0, "R3");
        // R4/R6: second block stalls, released exactly at the threshold
        step(1, 1, 0, "R4");
        step(1, 1, 5, "R6");
        step(1, 1, 127, "R6");
        step(1, 1, 128, "R6");
        // R5: rest of the block ignores free space
        for (int i = 0; i < 3; i++) step(1, 1, 0, "R5");
        // R4: one byte short at the next throttle point
        step(1, 1, 127, "R4");
        // R9: final beat with frame low, then idle
        step(0, 1, 300, "R9");
        step(0, 1, 300, "R9");

        // R8: initial wait state, then check the boundary position
        step(1, 0, 0, "R8");
        for (int i = 0; i < 3; i++) step(1, 1, 0, "R8");
        step(1, 0, 0, "R8");
        step(1, 1, 0, "R8");
        step(1, 1, 0, "R8");   // opening beat of the second block: stalls
        step(1, 1, 500, "R4");
        step(0, 1, 0, "R9");   // mid-block final beat
        // R9: new burst straight after, no free space, first block accepted
        for (int i = 0; i < 4; i++) step(1, 1, 0, "R9");
        step(1, 1, 0, "R4");
        step(0, 1, 128, "R9");

        // constrained random bursts
        for (int b = 0; b < 60; b++) begin
            int rem;
            int gap;
            rem = 2 + ($urandom % 30);
            gap = $urandom % 4;
            for (int g = 0; g < gap; g++) step(0, $urandom % 2, $urandom % 4096, "R2");
            while (rem > 0) begin
                int fr;
                fr = (($urandom % 3) == 0) ? int'($urandom % 128) : 128 + int'($urandom % 3968);
                step(rem > 1, ($urandom % 5) != 0, fr, "R4");
                if (exp_wr) rem--;
            end
        end
        step(0, 0, 0, "R2");
        step(0, 0, 0, "R2");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule